// File: doc/BRIEF.md
# Programmable Input Debounce Filter

This block cleans one slow external input before it reaches edge and level detection. The raw pin is first brought into the clock domain by a two-flop synchronizer. A filter stage then decides when the clean output may follow the synchronized level. The filter waits for a timeout measured in ticks of a shared one-microsecond timebase. The timeout is a 4-bit count multiplied by one of four unit lengths, and two configuration bits pick the unit.

A 2-bit mode field picks the filter behaviour. Mode 0 passes the synchronized level straight through. Mode 1 suppresses short pulses of either polarity. Mode 2 lets every fall through at once and delays only rises, so short low pulses survive. Mode 3 lets every rise through at once and delays only falls, so short high pulses survive. The filtered level is the pin's live status as the rest of the chip sees it. Software converts a requested time into the count and unit fields.

Top module: `pin_debounce_filter`

## Requirements
- R1: Two flops synchronize `pin_raw`. In bypass, a change on `pin_raw` that is driven between clock edges appears on `level_out` after the third rising edge.
- R2: While `rst_n` is low, `level_out` loads the synchronized pin level on each edge and no count is kept. With the pin held steady for four edges of reset, `level_out` equals the pin.
- R3: With `cfg_mode` = 0 the filter is bypassed. `level_out` follows the synchronized input on the next edge, whatever `us_tick` does.
- R4: With `cfg_mode` = 1, `level_out` takes a new level only after the synchronized input has differed from it on N consecutive tick cycles. This holds for rises and for falls.
- R5: In mode 1, a return of the synchronized input to the output level before N ticks have passed clears the count. A pulse shorter than N ticks never reaches `level_out`.
- R6: N = `cfg_count` × unit. The unit is chosen by {`cfg_big_sel`, `cfg_unit_sel`}: 00 selects UNIT_T0 (about 61 ticks), 01 selects UNIT_T1 (about 244), 10 selects UNIT_T2 (about 15625) and 11 selects UNIT_T3 (about 62500).
- R7: A `cfg_count` of 0 with filtering enabled gives N = 1.
- R8: With `cfg_mode` = 2, a fall of the synchronized input reaches `level_out` on the next edge. A rise needs N ticks as in R4.
- R9: With `cfg_mode` = 3, a rise of the synchronized input reaches `level_out` on the next edge. A fall needs N ticks as in R4.
- R10: Outside bypass, a delayed transition advances only on cycles with `us_tick` high. With the tick held low, the output holds indefinitely.
- R11: While the synchronized input equals `level_out`, the output stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse from the shared microsecond timebase |
| pin_raw | input | 1 | Asynchronous raw pin level |
| cfg_count | input | COUNT_W | Timeout count multiplier |
| cfg_unit_sel | input | 1 | Unit select, low bit |
| cfg_big_sel | input | 1 | Unit select, high bit (long units) |
| cfg_mode | input | 2 | 0 bypass, 1 both-direction, 2 keep low pulses, 3 keep high pulses |
| level_out | output | 1 | Filtered pin level |

## Verification
The hardest case to reach from the ports is a pulse that ends exactly one tick short of the timeout and is followed at once by a fresh transition. That case shows whether the count is cleared rather than carried over. The bench builds it by holding the pin at the new level for N-1 cycles and dropping it for one cycle with the tick running every cycle. It then checks that the final change still takes the full N ticks. A tick held low for many cycles in the middle of a pending change is used to show that the count advances only on ticks. A small set of unit lengths lets the bench sweep every count and unit code in both directions.

// File: rtl/dbf_pkg.sv
// Package: shared types and helpers for the debounce filter.
// Assumes the mode codes are fixed by the register field layout.
package dbf_pkg;

    typedef enum logic [1:0] {
        FLT_OFF       = 2'd0,
        FLT_BOTH      = 2'd1,
        FLT_KEEP_LOW  = 2'd2,
        FLT_KEEP_HIGH = 2'd3
    } flt_mode_e;

    // Largest of the four unit lengths, used to size the counter.
    function automatic int unsigned max_unit(input int unsigned a, input int unsigned b,
                                             input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/dbf_sync.sv
// Module: multi-flop synchronizer for one asynchronous bit.
// Assumes the input is slow against clk. The flops carry no reset on purpose,
// so that reset can load the filter with the real pin level.
module dbf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // Single capture flop.
            always_ff @(posedge clk) chain <= d_async;
        end else begin : g_many
            // Shift the raw level through the chain.
            always_ff @(posedge clk) chain <= {chain[STAGES-2:0], d_async};
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/dbf_limit.sv
// Module: turns count and unit-select fields into a timeout in ticks.
// Assumes COUNT_W-bit count; a zero count gives a one-tick timeout.
module dbf_limit #(
    parameter int COUNT_W = 4,
    parameter int LIM_W   = 20,
    parameter int UNIT_T0 = 61,
    parameter int UNIT_T1 = 244,
    parameter int UNIT_T2 = 15625,
    parameter int UNIT_T3 = 62500
) (
    input  logic [COUNT_W-1:0] count,
    input  logic               unit_sel,
    input  logic               big_sel,
    output logic [LIM_W-1:0]   limit
);
    localparam int NUM_UNITS = 4;
    localparam int UNIT_LEN [NUM_UNITS] = '{UNIT_T0, UNIT_T1, UNIT_T2, UNIT_T3};

    logic [LIM_W-1:0] unit_tab [NUM_UNITS];
    logic [LIM_W-1:0] unit_len;
    logic [LIM_W-1:0] product;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_UNITS; gi++) begin : g_unit
            assign unit_tab[gi] = LIM_W'(UNIT_LEN[gi]);
        end
    endgenerate

    // Select the unit from {big, unit} and scale by the count.
    always_comb begin
        unit_len = unit_tab[{big_sel, unit_sel}];
        product  = LIM_W'(count) * unit_len;
        limit    = (count == '0) ? LIM_W'(1) : product;
    end
endmodule

// File: rtl/dbf_core.sv
// Module: the filter state machine; one held level and one tick counter.
// Assumes sync_in is already synchronous and that limit is at least 1.
module dbf_core
    import dbf_pkg::*;
#(
    parameter int LIM_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             sync_in,
    input  flt_mode_e        mode,
    input  logic [LIM_W-1:0] limit,
    output logic             filt
);
    logic [LIM_W-1:0] cnt;
    logic [LIM_W-1:0] cnt_nx;
    logic             pass_now;

    // A move toward the preserved level bypasses the timeout.
    always_comb begin
        cnt_nx   = cnt + LIM_W'(1);
        pass_now = ((mode == FLT_KEEP_LOW)  && !sync_in) ||
                   ((mode == FLT_KEEP_HIGH) &&  sync_in);
    end

    // Hold the filtered level; count ticks while the input disagrees with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt <= sync_in;
            cnt  <= '0;
        end else if (mode == FLT_OFF || sync_in == filt || pass_now) begin
            filt <= sync_in;
            cnt  <= '0;
        end else if (tick) begin
            if (cnt_nx >= limit) begin
                filt <= sync_in;
                cnt  <= '0;
            end else begin
                cnt <= cnt_nx;
            end
        end
    end

    // R3: bypass copies the synchronized input on the next edge.
    assert_bypass_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FLT_OFF) |=> (filt == $past(sync_in)));

    // R8: in keep-low mode a fall passes at once.
    assert_keep_low_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FLT_KEEP_LOW && filt && !sync_in) |=> !filt);

    // R9: in keep-high mode a rise passes at once.
    assert_keep_high_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FLT_KEEP_HIGH && !filt && sync_in) |=> filt);

    // R10: without a tick the both-direction filter never moves.
    assert_no_tick_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FLT_BOTH && !tick) |=> $stable(filt));

    // R11: agreement between input and output keeps the output still.
    assert_agree_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_in == filt) |=> $stable(filt));
endmodule

// File: rtl/pin_debounce_filter.sv
// Module: top of the per-pin debounce filter: synchronizer, timeout
// selection and filter core. Assumes us_tick is a one-cycle pulse per
// microsecond from a shared timebase and that the configuration is quasi-static.
module pin_debounce_filter
    import dbf_pkg::*;
#(
    parameter int COUNT_W     = 4,
    parameter int SYNC_STAGES = 2,
    parameter int UNIT_T0     = 61,
    parameter int UNIT_T1     = 244,
    parameter int UNIT_T2     = 15625,
    parameter int UNIT_T3     = 62500
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               us_tick,
    input  logic               pin_raw,
    input  logic [COUNT_W-1:0] cfg_count,
    input  logic               cfg_unit_sel,
    input  logic               cfg_big_sel,
    input  logic [1:0]         cfg_mode,
    output logic               level_out
);
    localparam int unsigned MAX_UNIT  = max_unit(UNIT_T0, UNIT_T1, UNIT_T2, UNIT_T3);
    localparam int unsigned MAX_LIMIT = ((1 << COUNT_W) - 1) * MAX_UNIT;
    localparam int          LIM_W     = $clog2(MAX_LIMIT + 1);

    logic             sync_lvl;
    logic [LIM_W-1:0] limit;
    flt_mode_e        mode;

    assign mode = flt_mode_e'(cfg_mode);

    dbf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .d_async (pin_raw),
        .q_sync  (sync_lvl)
    );

    dbf_limit #(
        .COUNT_W (COUNT_W),
        .LIM_W   (LIM_W),
        .UNIT_T0 (UNIT_T0),
        .UNIT_T1 (UNIT_T1),
        .UNIT_T2 (UNIT_T2),
        .UNIT_T3 (UNIT_T3)
    ) u_limit (
        .count    (cfg_count),
        .unit_sel (cfg_unit_sel),
        .big_sel  (cfg_big_sel),
        .limit    (limit)
    );

    dbf_core #(.LIM_W(LIM_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (us_tick),
        .sync_in (sync_lvl),
        .mode    (mode),
        .limit   (limit),
        .filt    (level_out)
    );
endmodule

// File: tb/pin_debounce_filter_tb.sv
// Bench: sweeps counts, units and modes with short unit lengths and
// compares output latencies against values computed from the requirements.
module pin_debounce_filter_tb;
    localparam int U0 = 2, U1 = 3, U2 = 5, U3 = 7;
    localparam int SYNC_LAT = 2;  // edges from pin to synchronized level

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       us_tick = 1'b1;
    logic       pin_raw = 1'b0;
    logic [3:0] cfg_count = 4'd0;
    logic       cfg_unit_sel = 1'b0;
    logic       cfg_big_sel = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic       level_out;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pin_debounce_filter #(
        .UNIT_T0(U0), .UNIT_T1(U1), .UNIT_T2(U2), .UNIT_T3(U3)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .pin_raw(pin_raw),
        .cfg_count(cfg_count), .cfg_unit_sel(cfg_unit_sel),
        .cfg_big_sel(cfg_big_sel), .cfg_mode(cfg_mode), .level_out(level_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lim_of(input int c, input int u);
        int ul;
        case (u)
            0: ul = U0;
            1: ul = U1;
            2: ul = U2;
            default: ul = U3;
        endcase
        return (c == 0) ? 1 : c * ul;
    endfunction

    // Bring output to a level via bypass, then restore the mode (ends at negedge).
    task automatic settle(input logic lv);
        logic [1:0] m;
        m = cfg_mode;
        cfg_mode = 2'd0;
        pin_raw = lv;
        repeat (4) @(negedge clk);
        cfg_mode = m;
    endtask

    // Drive a new level and count edges until the output takes it.
    task automatic measure(input logic nl, input int maxc, output int lat);
        pin_raw = nl;
        lat = -1;
        for (int k = 1; k <= maxc; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (level_out == nl) begin
                lat = k;
                break;
            end
        end
    endtask

    task automatic set_cfg(input int c, input int u, input int m);
        cfg_count    = 4'(c);
        cfg_unit_sel = u[0];
        cfg_big_sel  = u[1];
        cfg_mode     = 2'(m);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int lat, lim, highs;

        // R2: reset loads the synchronized pin level.
        pin_raw = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R2 reset loads high pin", int'(level_out), 1);
        pin_raw = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R2 reset loads low pin", int'(level_out), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R3: bypass latency, with and without ticks.
        set_cfg(5, 3, 0);
        measure(1'b1, 10, lat); chk("R1 R3 bypass rise latency", lat, SYNC_LAT + 1);
        measure(1'b0, 10, lat); chk("R1 R3 bypass fall latency", lat, SYNC_LAT + 1);
        us_tick = 1'b0;
        measure(1'b1, 10, lat); chk("R3 bypass ignores tick", lat, SYNC_LAT + 1);
        us_tick = 1'b1;

        // R4/R6/R7: every count and unit, both directions, mode 1.
        for (int u = 0; u < 4; u++) begin
            for (int c = 0; c < 16; c++) begin
                set_cfg(c, u, 1);
                lim = lim_of(c, u);
                settle(1'b0);
                measure(1'b1, lim + 10, lat);
                chk((c == 0) ? "R7 zero count rise" : "R4 R6 both-mode rise", lat, SYNC_LAT + lim);
                measure(1'b0, lim + 10, lat);
                chk((c == 0) ? "R7 zero count fall" : "R4 R6 both-mode fall", lat, SYNC_LAT + lim);
            end
        end

        // R5: a pulse one tick short is dropped, and a restart needs the full time.
        set_cfg(3, 0, 1);
        lim = lim_of(3, 0);
        settle(1'b0);
        highs = 0;
        pin_raw = 1'b1;
        repeat (lim - 1) begin @(negedge clk); highs += int'(level_out); end
        pin_raw = 1'b0;
        repeat (20) begin @(negedge clk); highs += int'(level_out); end
        chk("R5 short pulse removed", highs, 0);
        pin_raw = 1'b1;
        repeat (lim - 1) begin @(negedge clk); highs += int'(level_out); end
        pin_raw = 1'b0;
        @(negedge clk); highs += int'(level_out);
        measure(1'b1, lim + 10, lat);
        chk("R5 no output before restart", highs, 0);
        chk("R5 restart needs full timeout", lat, SYNC_LAT + lim);

        // R8: keep-low mode.
        for (int c = 0; c < 16; c += 5) begin
            set_cfg(c, c % 4, 2);
            lim = lim_of(c, c % 4);
            settle(1'b1);
            measure(1'b0, lim + 10, lat); chk("R8 keep-low fall immediate", lat, SYNC_LAT + 1);
            measure(1'b1, lim + 10, lat); chk("R8 keep-low rise delayed", lat, SYNC_LAT + lim);
        end

        // R9: keep-high mode.
        for (int c = 0; c < 16; c += 5) begin
            set_cfg(c, (c + 1) % 4, 3);
            lim = lim_of(c, (c + 1) % 4);
            settle(1'b0);
            measure(1'b1, lim + 10, lat); chk("R9 keep-high rise immediate", lat, SYNC_LAT + 1);
            measure(1'b0, lim + 10, lat); chk("R9 keep-high fall delayed", lat, SYNC_LAT + lim);
        end

        // R10: no tick, no progress; then exactly lim ticked edges.
        set_cfg(2, 1, 1);
        lim = lim_of(2, 1);
        settle(1'b0);
        us_tick = 1'b0;
        pin_raw = 1'b1;
        repeat (40) @(negedge clk);
        chk("R10 held without tick", int'(level_out), 0);
        us_tick = 1'b1;
        lat = -1;
        for (int k = 1; k <= lim + 10; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (level_out) begin lat = k; break; end
        end
        chk("R10 ticks resume count", lat, lim);

        // R11: agreement keeps the output still in filtering modes.
        set_cfg(1, 0, 1);
        settle(1'b1);
        highs = 0;
        repeat (30) begin @(negedge clk); highs += int'(level_out); end
        chk("R11 stable high in both-mode", highs, 30);
        set_cfg(1, 0, 3);
        settle(1'b0);
        highs = 0;
        repeat (30) begin @(negedge clk); highs += int'(level_out); end
        chk("R11 stable low in keep-high mode", highs, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule